// File: doc/BRIEF.md
# Technology-Aware Trigger Hit Delay Aligner

This block lines up trigger hit bits in time before they leave for a global trigger processor. Each hit channel belongs either to a barrel layer or to an endcap sector. Every channel is sampled on a slow tick enable, `tickEn`, which marks one clock in eight of the bunch clock. The delays are counted in these ticks. All channels share one programmable common delay. Channels read out by resistive-plate chambers also get a second programmable delay on top of the common one. This second delay corrects the chambers' own timing offset against streamer-tube channels.

Endcap channels are always chamber channels. One mode input sets how the barrel is instrumented. With the mode set, the whole barrel is streamer tubes. With the mode clear, four fixed barrel layers are chamber layers. The delay settings and the mode are captured only on a load strobe. After a load, and after reset, the pipelines are held empty and the valid output stays low until stale data can no longer come out.

Top module: `hitDelayAligner`

## Requirements
- R1: The 2-bit common delay `cfgCommon` (value G, 0 to 3) delays every channel by G ticks beyond the base pipeline, whatever the channel's region or technology.
- R2: The 2-bit chamber delay `cfgChamber` (value C, 0 to 3) adds C further ticks, but only on channels classed as chamber channels. The other channels get exactly G.
- R3: Every endcap channel is a chamber channel in both mode settings, so its delay is always G+C.
- R4: With `cfgBarrelAllTube` = 1, every barrel channel has delay G.
- R5: With `cfgBarrelAllTube` = 0, the barrel bits at positions 0, 2, 3 and 5 of `barrelHits` have delay G+C. All other barrel bits have delay G.
- R6: Hits are sampled only at a clock edge where `tickEn` = 1. Take the input captured at tick n. For a channel with total delay D, it appears on the output after the edge of tick n+D, so D = 0 means it appears right after its own capture edge. Between ticks the outputs do not change, whatever the inputs do. No input reaches an output without a register in the path.
- R7: The configuration inputs act only at a clock edge where `cfgLoad` = 1. Changing them at any other time has no effect on the outputs.
- R8: A load clears every pipeline stage in the same edge and drops `outValid`. The next 6 ticks keep all outputs at zero and `outValid` low. `outValid` rises at the edge of the sixth tick, and hits are captured again from the seventh tick on.
- R9: When `cfgLoad` and `tickEn` are high in the same cycle, the load wins. The hit at that tick is discarded, and that tick does not count toward the 6 flush ticks.
- R10: A synchronous active-high `rst` clears all stages and `outValid` and sets G = 0, C = 0 and the mode to 0. It then runs the same 6-tick flush as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle enable that marks a tick |
| cfgLoad | input | 1 | Capture strobe for the configuration inputs |
| cfgCommon | input | 2 | Common delay in ticks, applied to all channels |
| cfgChamber | input | 2 | Extra delay in ticks for chamber channels |
| cfgBarrelAllTube | input | 1 | 1: whole barrel is streamer tubes; 0: layers 0, 2, 3 and 5 are chambers |
| barrelHits | input | 10 | Barrel hit bits, one per layer |
| endcapHits | input | 16 | Endcap hit bits |
| barrelOut | output | 10 | Delayed barrel hits |
| endcapOut | output | 16 | Delayed endcap hits |
| outValid | output | 1 | High when the outputs carry aligned data |

## Verification
A configuration load and a sampling tick can fall in the same clock cycle. The bench provokes this by raising `cfgLoad` and `tickEn` together, on a fixed share of the configurations in its sweep. The outcome counts as correct only under these conditions. Right after that edge, the outputs are zero and `outValid` is low. Exactly six more ticks pass before `outValid` rises. None of the hits presented at the colliding tick ever reaches an output. The sweep covers all 32 pairs of delay settings and mode, and each output is compared with the hit captured G or G+C ticks earlier.

// File: rtl/hitAlignPkg.sv
package hitAlignPkg;

  // Strobes from the control to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic shift;  // advance every lane by one stage, capturing new hits
    logic clear;  // zero every stage (load or flush tick)
  } alignStrbT;

endpackage

// File: rtl/hitAlignCtrl.sv
module hitAlignCtrl
  import hitAlignPkg::*;
#(
  parameter int BARREL_W = 10,
  parameter int ENDCAP_W = 16,
  parameter int DLY_W = 2,
  parameter logic [BARREL_W-1:0] BARREL_CHAMBER_MASK = 10'b00_0010_1101,
  localparam int CH_W = BARREL_W + ENDCAP_W,
  localparam int MAX_DLY = 2 * ((1 << DLY_W) - 1),
  localparam int CNT_W = $clog2(MAX_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              cfgLoad,
  input  logic [DLY_W-1:0]  cfgCommon,
  input  logic [DLY_W-1:0]  cfgChamber,
  input  logic              cfgBarrelAllTube,
  output alignStrbT         strb,
  output logic [DLY_W-1:0]  commonDly,
  output logic [DLY_W-1:0]  chamberDly,
  output logic [CH_W-1:0]   chamberSel,
  output logic              outValid
);

  localparam logic [CNT_W-1:0] FLUSH_TICKS = CNT_W'(MAX_DLY);

  logic             allTubeQ;
  logic [CNT_W-1:0] flushCnt;
  logic [CNT_W-1:0] flushCntNext;

  // Configuration shadow registers: written only on a load.
  always_ff @(posedge clk) begin
    if (rst) begin
      commonDly  <= '0;
      chamberDly <= '0;
      allTubeQ   <= 1'b0;
    end else if (cfgLoad) begin
      commonDly  <= cfgCommon;
      chamberDly <= cfgChamber;
      allTubeQ   <= cfgBarrelAllTube;
    end
  end

  // Per-channel technology classification.
  for (genvar i = 0; i < BARREL_W; i++) begin : gBarrelSel
    assign chamberSel[i] = BARREL_CHAMBER_MASK[i] & ~allTubeQ;
  end
  for (genvar j = 0; j < ENDCAP_W; j++) begin : gEndcapSel
    assign chamberSel[BARREL_W + j] = 1'b1;
  end

  // Flush sequencing: load has priority over a coincident tick.
  always_comb begin
    strb.clear   = 1'b0;
    strb.shift   = 1'b0;
    flushCntNext = flushCnt;
    if (cfgLoad) begin
      strb.clear   = 1'b1;
      flushCntNext = FLUSH_TICKS;
    end else if (tickEn) begin
      if (flushCnt != '0) begin
        strb.clear   = 1'b1;
        flushCntNext = flushCnt - 1'b1;
      end else begin
        strb.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flushCnt <= FLUSH_TICKS;
      outValid <= 1'b0;
    end else begin
      flushCnt <= flushCntNext;
      outValid <= (flushCntNext == '0);
    end
  end

  AST_VALID_LOW_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (flushCnt != '0) |-> !outValid) else $error("valid during flush"); // R8

  AST_LOAD_RESTARTS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    cfgLoad |=> (flushCnt == FLUSH_TICKS) && !outValid) else $error("load flush"); // R8

  AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    (cfgLoad && tickEn) |=> (flushCnt == FLUSH_TICKS)) else $error("collision"); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfgLoad |=> $stable(commonDly) && $stable(chamberDly) && $stable(chamberSel))
    else $error("cfg moved"); // R7

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !cfgLoad) |=> outValid) else $error("valid dropped"); // R8

  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (rst)
    flushCnt <= FLUSH_TICKS) else $error("flush count range"); // R10

endmodule

// File: rtl/hitAlignPath.sv
module hitAlignPath
  import hitAlignPkg::*;
#(
  parameter int CH_W = 26,
  parameter int DLY_W = 2,
  localparam int MAX_DLY = 2 * ((1 << DLY_W) - 1),
  localparam int TAP_W = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  alignStrbT        strb,
  input  logic [DLY_W-1:0] commonDly,
  input  logic [DLY_W-1:0] chamberDly,
  input  logic [CH_W-1:0]  chamberSel,
  input  logic [CH_W-1:0]  hitIn,
  output logic [CH_W-1:0]  hitOut
);

  for (genvar c = 0; c < CH_W; c++) begin : gLane
    logic [MAX_DLY:0] stages;
    logic [TAP_W-1:0] tap;

    always_ff @(posedge clk) begin
      if (rst || strb.clear) begin
        stages <= '0;
      end else if (strb.shift) begin
        stages <= {stages[MAX_DLY-1:0], hitIn[c]};
      end
    end

    assign tap = TAP_W'(commonDly) + (chamberSel[c] ? TAP_W'(chamberDly) : '0);
    assign hitOut[c] = stages[tap];
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shift, strb.clear})) else $error("strobe clash"); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (hitOut == '0)) else $error("clear left data"); // R8

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (!strb.shift && !strb.clear) |=> $stable(hitOut)) else $error("output moved"); // R6

endmodule

// File: rtl/hitDelayAligner.sv
module hitDelayAligner
  import hitAlignPkg::*;
#(
  parameter int BARREL_W = 10,
  parameter int ENDCAP_W = 16,
  parameter int DLY_W = 2,
  parameter logic [BARREL_W-1:0] BARREL_CHAMBER_MASK = 10'b00_0010_1101,
  localparam int CH_W = BARREL_W + ENDCAP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic                cfgLoad,
  input  logic [DLY_W-1:0]    cfgCommon,
  input  logic [DLY_W-1:0]    cfgChamber,
  input  logic                cfgBarrelAllTube,
  input  logic [BARREL_W-1:0] barrelHits,
  input  logic [ENDCAP_W-1:0] endcapHits,
  output logic [BARREL_W-1:0] barrelOut,
  output logic [ENDCAP_W-1:0] endcapOut,
  output logic                outValid
);

  alignStrbT        strb;
  logic [DLY_W-1:0] commonDly;
  logic [DLY_W-1:0] chamberDly;
  logic [CH_W-1:0]  chamberSel;
  logic [CH_W-1:0]  hitOut;

  hitAlignCtrl #(
    .BARREL_W(BARREL_W), .ENDCAP_W(ENDCAP_W), .DLY_W(DLY_W),
    .BARREL_CHAMBER_MASK(BARREL_CHAMBER_MASK)
  ) uCtrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cfgLoad(cfgLoad),
    .cfgCommon(cfgCommon), .cfgChamber(cfgChamber),
    .cfgBarrelAllTube(cfgBarrelAllTube), .strb(strb),
    .commonDly(commonDly), .chamberDly(chamberDly),
    .chamberSel(chamberSel), .outValid(outValid)
  );

  hitAlignPath #(.CH_W(CH_W), .DLY_W(DLY_W)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .commonDly(commonDly),
    .chamberDly(chamberDly), .chamberSel(chamberSel),
    .hitIn({endcapHits, barrelHits}), .hitOut(hitOut)
  );

  assign barrelOut = hitOut[BARREL_W-1:0];
  assign endcapOut = hitOut[CH_W-1:BARREL_W];

endmodule

// File: tb/tb_hitDelayAligner.sv
`timescale 1ns/1ps
module tb_hitDelayAligner;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic cfgLoad = 1'b0;
  logic [1:0] cfgCommon = '0;
  logic [1:0] cfgChamber = '0;
  logic cfgBarrelAllTube = 1'b0;
  logic [9:0] barrelHits = '0;
  logic [15:0] endcapHits = '0;
  logic [9:0] barrelOut;
  logic [15:0] endcapOut;
  logic outValid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int curG = 0;
  int curC = 0;
  int curTube = 0;
  logic [9:0] capB [0:31];
  logic [15:0] capE [0:31];
  int capN = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  hitDelayAligner dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cfgLoad(cfgLoad),
    .cfgCommon(cfgCommon), .cfgChamber(cfgChamber),
    .cfgBarrelAllTube(cfgBarrelAllTube), .barrelHits(barrelHits),
    .endcapHits(endcapHits), .barrelOut(barrelOut),
    .endcapOut(endcapOut), .outValid(outValid)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Chamber classification: endcap always (R3); barrel bits 0,2,3,5 when mode 0 (R5).
  function automatic bit isChamberBarrel(input int i);
    return (curTube == 0) && (i == 0 || i == 2 || i == 3 || i == 5);
  endfunction

  task automatic checkAligned(input string req);
    logic [9:0] eb;
    logic [15:0] ee;
    int last;
    int d;
    last = capN - 1;
    for (int i = 0; i < 10; i++) begin
      d = curG + (isChamberBarrel(i) ? curC : 0);
      eb[i] = (last - d >= 0) ? capB[last - d][i] : 1'b0;
    end
    d = curG + curC;
    for (int j = 0; j < 16; j++) ee[j] = (last - d >= 0) ? capE[last - d][j] : 1'b0;
    checkEq(req, "barrelOut", 32'(barrelOut), 32'(eb));
    checkEq(req, "endcapOut", 32'(endcapOut), 32'(ee));
    checkEq(req, "outValid", 32'(outValid), 32'd1);
  endtask

  // One tick with fresh hits; inputs are scrambled between ticks (R6).
  task automatic doTick(input bit capture);
    logic [31:0] r;
    logic [9:0] hb;
    logic [15:0] he;
    r = nextRand();
    hb = r[25:16];
    he = r[15:0];
    @(negedge clk);
    barrelHits = hb;
    endcapHits = he;
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    if (capture) begin
      capB[capN] = hb;
      capE[capN] = he;
      capN++;
    end
  endtask

  task automatic checkQuietBetweenTicks();
    logic [9:0] b0;
    logic [15:0] e0;
    b0 = barrelOut;
    e0 = endcapOut;
    barrelHits = ~barrelHits;
    endcapHits = ~endcapHits;
    @(negedge clk);
    @(negedge clk);
    checkEq("R6", "barrel held between ticks", 32'(barrelOut), 32'(b0));
    checkEq("R6", "endcap held between ticks", 32'(endcapOut), 32'(e0));
  endtask

  // Six flush ticks: zero outputs, valid rises only at the sixth (R8).
  task automatic runFlush(input string req);
    for (int k = 1; k <= 6; k++) begin
      doTick(1'b0);
      checkEq(req, "flush outputs zero", 32'({barrelOut, endcapOut}), 32'd0);
      checkEq(req, "flush valid", 32'(outValid), (k == 6) ? 32'd1 : 32'd0);
    end
    capN = 0;
  endtask

  task automatic loadCfg(input int g, input int c, input int tube, input bit withTick);
    @(negedge clk);
    cfgCommon = 2'(g);
    cfgChamber = 2'(c);
    cfgBarrelAllTube = tube[0];
    cfgLoad = 1'b1;
    tickEn = withTick;
    barrelHits = 10'h3FF;
    endcapHits = 16'hFFFF;
    @(negedge clk);
    cfgLoad = 1'b0;
    tickEn = 1'b0;
    curG = g;
    curC = c;
    curTube = tube;
    checkEq(withTick ? "R9" : "R8", "outputs zero after load",
            32'({barrelOut, endcapOut}), 32'd0);
    checkEq(withTick ? "R9" : "R8", "valid low after load", 32'(outValid), 32'd0);
    // Scramble config inputs without a load: must have no effect (R7).
    cfgCommon = ~cfgCommon;
    cfgChamber = cfgChamber + 2'd1;
    cfgBarrelAllTube = ~cfgBarrelAllTube;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R10", "reset outputs", 32'({barrelOut, endcapOut}), 32'd0);
    checkEq("R10", "reset valid", 32'(outValid), 32'd0);
    rst = 1'b0;
    runFlush("R10");
    // Post-reset config is G=0, C=0: delay zero on every channel (R6, R10).
    for (int k = 0; k < 4; k++) begin
      doTick(1'b1);
      checkAligned("R10");
    end

    for (int cfg = 0; cfg < 32; cfg++) begin
      int g;
      int c;
      int tube;
      string req;
      g = cfg % 4;
      c = (cfg / 4) % 4;
      tube = cfg / 16;
      loadCfg(g, c, tube, (cfg % 3) == 0);
      runFlush("R8");
      if (tube == 1) req = "R4";
      else if (c != 0) req = "R5";
      else req = "R1";
      for (int k = 0; k < 10; k++) begin
        doTick(1'b1);
        checkAligned(req);
        if (c != 0) checkAligned("R2");
        checkAligned("R3");
        checkAligned("R7");
        if (k == 4) checkQuietBetweenTicks();
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule